// File: doc/BRIEF.md
# JTAG Debug Test Access Port

This block is a boundary-scan test access port for a chip that also wants a debug path through the same four or five pins. It is clocked only by TCK and is cleared by an active-low TRST. It contains the sixteen-state TAP controller and a 6-bit instruction register. The data registers are a one-bit bypass stage, a hard-wired 32-bit identification word, a boundary-scan chain with update latches and a file of sixteen 32-bit debug registers.

A private debug opcode carries a 4-bit register index in its low bits. When that opcode is loaded, Capture-DR takes a snapshot of the indexed debug register into a 32-bit shift stage. Update-DR then writes the shifted word back to the same register.

The same register file has a second access port that on-chip logic uses to exchange words with an external debugger. Reads on that port are combinational. Writes on that port take effect on the falling edge of TCK.

The boundary chain holds `NIN` input cells and `NOUT` output cells. While EXTEST is active, the output pads come from the update latches. Under any other instruction, the output pads follow the core.

Top module: `jtag_dbg_tap`

## Requirements
- R1: The controller follows the standard sixteen-state TAP graph on rising TCK. Five consecutive rising edges with TMS=1 reach Test-Logic-Reset from any state, and TMS=0 in Test-Logic-Reset moves to Run-Test/Idle.
- R2: The instruction register is 6 bits wide and is shifted LSB first from TDI toward TDO. Capture-IR loads 000001, so the first bit that leaves on TDO is 1. A new instruction takes effect on the falling TCK edge in Update-IR.
- R3: Test-Logic-Reset and a low `trst_n` both select IDCODE (011111). A low `trst_n` also clears the boundary update latches, so the pads return to the core values.
- R4: Under IDCODE, Capture-DR loads the 32-bit `ID_VALUE`, which is then shifted out LSB first. Bits shifted in on TDI never change the identification value that later captures return.
- R5: BYPASS (111111) and every opcode without an assignment place a one-bit stage between TDI and TDO. That stage captures 0, so the output stream is a 0 followed by the input stream delayed by one TCK.
- R6: The debug opcode is 10SSSS, where SSSS (IR bits 3:0) is the register index. Capture-DR loads the indexed register LSB first. On the falling edge in Update-DR the shifted word is written back to that register, and the other fifteen registers keep their values.
- R7: `sys_rdata` shows the register selected by `sys_addr` combinationally. When `sys_we` is high, the falling TCK edge writes `sys_wdata` into that register. If a JTAG update hits the same register on the same edge, the JTAG word wins. `trst_n` clears all sixteen registers to 0.
- R8: SAMPLE/PRELOAD is opcode 000001. Capture-DR loads chain bits [NIN-1:0] from `pin_in` and bits [NIN+NOUT-1:NIN] from the values on `pad_out`. Update-DR copies the output part of the chain into the update latches, while `pad_out` keeps following `core_out`.
- R9: EXTEST is opcode 000000. While it is active, `pad_out` is driven from the output update latches and ignores `core_out`. Capture-DR under EXTEST samples `pin_in` and `pad_out` in the same bit positions as in R8.
- R10: TDO changes only on the falling TCK edge. `tdo_en` is high exactly while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling TCK |
| tdo_en | output | 1 | High while a shift state drives TDO |
| pin_in | input | NIN | States of the input pads |
| core_out | input | NOUT | Values the core wants on the output pads |
| pad_out | output | NOUT | Values sent to the output pad drivers |
| sys_we | input | 1 | System-side write strobe, sampled on falling TCK |
| sys_addr | input | 4 | System-side register index |
| sys_wdata | input | 32 | System-side write word |
| sys_rdata | output | 32 | Register selected by `sys_addr` |

## Verification
The assertions check these properties on every TCK edge:
- The five-ones return to Test-Logic-Reset.
- The values loaded by Capture-IR, by the bypass stage, by the identification word and by the debug snapshot.
- The instruction register holding IDCODE in Test-Logic-Reset.
- The `tdo_en` window.

Some behaviours only the bench scenarios can show, because they depend on whole shift sequences:
- The LSB-first order of what leaves on TDO.
- The delay through the bypass stage.
- The isolation between debug registers.
- JTAG winning over the system port when both write the same register on one edge.
- Preload leaving the pads alone until EXTEST takes over.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;

    localparam int IR_W   = 6;
    localparam int DBG_W  = 32;
    localparam int DBG_AW = 4;
    localparam int NREG   = 1 << DBG_AW;

    localparam logic [IR_W-1:0] OP_EXTEST  = 6'b000000;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 6'b000001;
    localparam logic [IR_W-1:0] OP_IDCODE  = 6'b011111;
    localparam logic [IR_W-1:0] OP_BYPASS  = 6'b111111;
    localparam logic [1:0]      OP_DBG_HI  = 2'b10;
    localparam logic [IR_W-1:0] IR_CAPTURE = 6'b000001;

    typedef enum logic [3:0] {
        TLR, RTI,
        SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
    } tap_state_e;

    typedef enum logic [2:0] {
        K_EXTEST, K_SAMPLE, K_IDCODE, K_BYPASS, K_DEBUG
    } ins_kind_e;

    typedef struct packed {
        ins_kind_e         kind;
        logic [DBG_AW-1:0] dbg_addr;
    } ins_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        case (s)
            TLR:    return m ? TLR    : RTI;
            RTI:    return m ? SEL_DR : RTI;
            SEL_DR: return m ? SEL_IR : CAP_DR;
            CAP_DR: return m ? EX1_DR : SH_DR;
            SH_DR:  return m ? EX1_DR : SH_DR;
            EX1_DR: return m ? UPD_DR : PAU_DR;
            PAU_DR: return m ? EX2_DR : PAU_DR;
            EX2_DR: return m ? UPD_DR : SH_DR;
            UPD_DR: return m ? SEL_DR : RTI;
            SEL_IR: return m ? TLR    : CAP_IR;
            CAP_IR: return m ? EX1_IR : SH_IR;
            SH_IR:  return m ? EX1_IR : SH_IR;
            EX1_IR: return m ? UPD_IR : PAU_IR;
            PAU_IR: return m ? EX2_IR : PAU_IR;
            EX2_IR: return m ? UPD_IR : SH_IR;
            UPD_IR: return m ? SEL_DR : RTI;
            default: return TLR;
        endcase
    endfunction

    function automatic ins_t decode_ins(input logic [IR_W-1:0] op);
        ins_t r;
        r.dbg_addr = op[DBG_AW-1:0];
        if (op[IR_W-1:IR_W-2] == OP_DBG_HI) r.kind = K_DEBUG;
        else if (op == OP_EXTEST)           r.kind = K_EXTEST;
        else if (op == OP_SAMPLE)           r.kind = K_SAMPLE;
        else if (op == OP_IDCODE)           r.kind = K_IDCODE;
        else                                r.kind = K_BYPASS;
        return r;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= TLR;
        else         state <= tap_next(state, tms);
    end

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic            ir_so,
    output logic [IR_W-1:0] ir_shift,
    output logic [IR_W-1:0] ir_q,
    output ins_t            ins
);

    // capture and shift on rising TCK
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)              ir_shift <= IR_CAPTURE;
        else if (state == CAP_IR) ir_shift <= IR_CAPTURE;
        else if (state == SH_IR)  ir_shift <= {tdi, ir_shift[IR_W-1:1]};
    end

    // active instruction changes on falling TCK
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)              ir_q <= OP_IDCODE;
        else if (state == TLR)    ir_q <= OP_IDCODE;
        else if (state == UPD_IR) ir_q <= ir_shift;
    end

    assign ir_so = ir_shift[0];
    assign ins   = decode_ins(ir_q);

endmodule

// File: rtl/tap_dbg_rf.sv
`timescale 1ns/1ps
module tap_dbg_rf
    import tap_pkg::*;
(
    input  logic              tck,
    input  logic              trst_n,
    input  logic              jt_we,
    input  logic [DBG_AW-1:0] jt_addr,
    input  logic [DBG_W-1:0]  jt_wdata,
    output logic [DBG_W-1:0]  jt_rdata,
    input  logic              sys_we,
    input  logic [DBG_AW-1:0] sys_addr,
    input  logic [DBG_W-1:0]  sys_wdata,
    output logic [DBG_W-1:0]  sys_rdata
);

    logic [DBG_W-1:0] ent_view [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        localparam logic [DBG_AW-1:0] IDX = DBG_AW'(g);
        logic [DBG_W-1:0] q;
        always_ff @(negedge tck or negedge trst_n) begin
            if (!trst_n)                         q <= '0;
            else if (jt_we && jt_addr == IDX)    q <= jt_wdata;
            else if (sys_we && sys_addr == IDX)  q <= sys_wdata;
        end
        assign ent_view[g] = q;
    end

    assign jt_rdata  = ent_view[jt_addr];
    assign sys_rdata = ent_view[sys_addr];

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
    import tap_pkg::*;
#(
    parameter int          NIN      = 4,
    parameter int          NOUT     = 4,
    parameter logic [31:0] ID_VALUE = 32'h4B7D_20A9
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  tap_state_e        state,
    input  ins_t              ins,
    input  logic [NIN-1:0]    pin_in,
    input  logic [NOUT-1:0]   core_out,
    input  logic [DBG_W-1:0]  dbg_rdata,
    output logic              dr_so,
    output logic [NOUT-1:0]   pad_out,
    output logic [NOUT-1:0]   upd_out,
    output logic              dbg_we,
    output logic [DBG_AW-1:0] dbg_addr,
    output logic [DBG_W-1:0]  dbg_wdata,
    output logic              byp_q,
    output logic [DBG_W-1:0]  word_q
);

    localparam int NB = NIN + NOUT;

    logic [NB-1:0]   bsr_q;
    logic [NOUT-1:0] latch_q;
    logic            bsr_sel;

    assign bsr_sel = (ins.kind == K_EXTEST) || (ins.kind == K_SAMPLE);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q  <= 1'b0;
            word_q <= '0;
            bsr_q  <= '0;
        end else if (state == CAP_DR) begin
            case (ins.kind)
                K_BYPASS: byp_q  <= 1'b0;
                K_IDCODE: word_q <= ID_VALUE;
                K_DEBUG:  word_q <= dbg_rdata;
                default:  bsr_q  <= {pad_out, pin_in};
            endcase
        end else if (state == SH_DR) begin
            case (ins.kind)
                K_BYPASS:         byp_q  <= tdi;
                K_IDCODE, K_DEBUG: word_q <= {tdi, word_q[DBG_W-1:1]};
                default:          bsr_q  <= {tdi, bsr_q[NB-1:1]};
            endcase
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)                          latch_q <= '0;
        else if (state == UPD_DR && bsr_sel)  latch_q <= bsr_q[NB-1:NIN];
    end

    always_comb begin
        case (ins.kind)
            K_BYPASS:          dr_so = byp_q;
            K_IDCODE, K_DEBUG: dr_so = word_q[0];
            default:           dr_so = bsr_q[0];
        endcase
    end

    assign upd_out   = latch_q;
    assign pad_out   = (ins.kind == K_EXTEST) ? latch_q : core_out;
    assign dbg_we    = (state == UPD_DR) && (ins.kind == K_DEBUG);
    assign dbg_addr  = ins.dbg_addr;
    assign dbg_wdata = word_q;

endmodule

// File: rtl/jtag_dbg_tap.sv
`timescale 1ns/1ps
module jtag_dbg_tap
    import tap_pkg::*;
#(
    parameter int          NIN      = 4,
    parameter int          NOUT     = 4,
    parameter logic [31:0] ID_VALUE = 32'h4B7D_20A9
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              tdo_en,
    input  logic [NIN-1:0]    pin_in,
    input  logic [NOUT-1:0]   core_out,
    output logic [NOUT-1:0]   pad_out,
    input  logic              sys_we,
    input  logic [DBG_AW-1:0] sys_addr,
    input  logic [DBG_W-1:0]  sys_wdata,
    output logic [DBG_W-1:0]  sys_rdata
);

    tap_state_e        state;
    ins_t              ins;
    logic              ir_so, dr_so;
    logic [IR_W-1:0]   ir_shift, ir_q;
    logic              dbg_we, byp_q;
    logic [DBG_AW-1:0] dbg_addr;
    logic [DBG_W-1:0]  dbg_wdata, dbg_rdata, word_q;
    logic [NOUT-1:0]   upd_out;

    tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
    );

    tap_ir u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
        .ir_so(ir_so), .ir_shift(ir_shift), .ir_q(ir_q), .ins(ins)
    );

    tap_dr #(.NIN(NIN), .NOUT(NOUT), .ID_VALUE(ID_VALUE)) u_dr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state), .ins(ins),
        .pin_in(pin_in), .core_out(core_out), .dbg_rdata(dbg_rdata),
        .dr_so(dr_so), .pad_out(pad_out), .upd_out(upd_out),
        .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
        .byp_q(byp_q), .word_q(word_q)
    );

    tap_dbg_rf u_rf (
        .tck(tck), .trst_n(trst_n),
        .jt_we(dbg_we), .jt_addr(dbg_addr), .jt_wdata(dbg_wdata), .jt_rdata(dbg_rdata),
        .sys_we(sys_we), .sys_addr(sys_addr), .sys_wdata(sys_wdata), .sys_rdata(sys_rdata)
    );

    // serial output launched on falling TCK
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (state == SH_IR) || (state == SH_DR);
            tdo    <= (state == SH_IR) ? ir_so : dr_so;
        end
    end

endmodule

// File: rtl/tap_chk.sv
`timescale 1ns/1ps
module tap_chk
    import tap_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h4B7D_20A9
) (
    input logic             tck,
    input logic             trst_n,
    input logic             tms,
    input tap_state_e       st,
    input ins_t             ins,
    input logic [IR_W-1:0]  ir_q,
    input logic [IR_W-1:0]  ir_shift,
    input logic             byp_q,
    input logic [DBG_W-1:0] word_q,
    input logic [DBG_W-1:0] dbg_rdata,
    input logic             tdo_en
);

    logic [2:0] ones_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)            ones_q <= '0;
        else if (!tms)          ones_q <= '0;
        else if (ones_q < 3'd5) ones_q <= ones_q + 3'd1;
    end

    // R1
    five_ones_tlr_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_q == 3'd5) |-> (st == TLR));

    // R2
    ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (st == CAP_IR) |=> (ir_shift == IR_CAPTURE));

    // R3
    tlr_idcode_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (st == TLR) |-> (ir_q == OP_IDCODE));

    // R4
    id_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (st == CAP_DR && ins.kind == K_IDCODE) |=> (word_q == ID_VALUE));

    // R5
    bypass_zero_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (st == CAP_DR && ins.kind == K_BYPASS) |=> (byp_q == 1'b0));

    // R6
    dbg_snapshot_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (st == CAP_DR && ins.kind == K_DEBUG) |=> (word_q == $past(dbg_rdata)));

    // R10
    tdo_window_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en == (st == SH_IR || st == SH_DR));

endmodule

bind jtag_dbg_tap tap_chk #(.ID_VALUE(ID_VALUE)) u_chk (
    .tck(tck), .trst_n(trst_n), .tms(tms), .st(state), .ins(ins),
    .ir_q(ir_q), .ir_shift(ir_shift), .byp_q(byp_q), .word_q(word_q),
    .dbg_rdata(dbg_rdata), .tdo_en(tdo_en)
);

// File: tb/jtag_dbg_tap_tb.sv
`timescale 1ns/1ps
module jtag_dbg_tap_tb;

    localparam int          NIN    = 4;
    localparam int          NOUT   = 4;
    localparam logic [31:0] ID_EXP = 32'h4B7D_20A9;
    localparam logic [5:0]  B_EXTEST = 6'b000000;
    localparam logic [5:0]  B_SAMPLE = 6'b000001;
    localparam logic [5:0]  B_BYPASS = 6'b111111;

    logic            tck = 1'b0;
    logic            trst_n, tms, tdi, tdo, tdo_en;
    logic [NIN-1:0]  pin_in;
    logic [NOUT-1:0] core_out, pad_out;
    logic            sys_we;
    logic [3:0]      sys_addr;
    logic [31:0]     sys_wdata, sys_rdata;

    jtag_dbg_tap #(.NIN(NIN), .NOUT(NOUT), .ID_VALUE(ID_EXP)) u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .pin_in(pin_in), .core_out(core_out), .pad_out(pad_out),
        .sys_we(sys_we), .sys_addr(sys_addr), .sys_wdata(sys_wdata), .sys_rdata(sys_rdata)
    );

    always #2.5 tck = ~tck;

    int          checks = 0;
    int          fails  = 0;
    int          en_bad = 0;
    logic        last_tdo, last_en;
    logic [31:0] model [16];
    logic        clash = 1'b0;
    logic [3:0]  clash_addr = '0;
    logic [31:0] clash_data = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_bypass(input logic [63:0] d, input int n);
        logic [63:0] r = '0;
        for (int i = 1; i < n; i++) r[i] = d[i-1];
        return r;
    endfunction

    // called just after a falling edge; returns just after the next one
    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        #1;
        last_tdo = tdo;
        last_en  = tdo_en;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic shift_ir(input logic [5:0] op, output logic [5:0] cap);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 6; i++) begin
            step(i == 5, op[i]);
            cap[i] = last_tdo;
            if (!last_en) en_bad++;
        end
        step(1, 0);
        step(0, 0);
        step(0, 0);
        if (last_en) en_bad++;
    endtask

    task automatic shift_dr(input logic [63:0] din, input int n, output logic [63:0] dout);
        dout = '0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i]);
            dout[i] = last_tdo;
            if (!last_en) en_bad++;
        end
        if (clash) begin
            sys_we    = 1'b1;
            sys_addr  = clash_addr;
            sys_wdata = clash_data;
        end
        step(1, 0);
        sys_we = 1'b0;
        step(0, 0);
        step(0, 0);
        if (last_en) en_bad++;
    endtask

    task automatic sys_write(input logic [3:0] a, input logic [31:0] w);
        sys_we = 1'b1; sys_addr = a; sys_wdata = w;
        step(0, 0);
        sys_we = 1'b0;
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] d, r;
        logic [5:0]  cap;
        logic [3:0]  a;
        logic [31:0] w;
        void'($urandom(32'd1234));
        trst_n = 0; tms = 1; tdi = 0; sys_we = 0; sys_addr = '0; sys_wdata = '0;
        pin_in = 4'($urandom); core_out = 4'($urandom);
        for (int i = 0; i < 16; i++) model[i] = '0;
        #12;
        @(negedge tck); #1;
        trst_n = 1;

        // reset state
        chk(tdo_en == 1'b0, "R10 idle enable", 64'(tdo_en), 0);
        chk(pad_out == core_out, "R3 pads follow core after reset", 64'(pad_out), 64'(core_out));
        step(0, 0);
        r = {$urandom, $urandom};
        shift_dr(r, 32, d);
        chk(d[31:0] == ID_EXP, "R3 IDCODE after reset", d, 64'(ID_EXP));
        shift_dr(~r, 32, d);
        chk(d[31:0] == ID_EXP, "R4 ID unchanged by shifted data", d, 64'(ID_EXP));

        // instruction capture and bypass
        shift_ir(B_BYPASS, cap);
        chk(cap == 6'b000001, "R2 capture pattern", 64'(cap), 64'b000001);
        r = {$urandom, $urandom};
        shift_dr(r, 16, d);
        chk(d[15:0] == exp_bypass(r, 16), "R5 bypass delay", d[15:0], exp_bypass(r, 16));
        shift_ir(6'b010101, cap);
        r = {$urandom, $urandom};
        shift_dr(r, 12, d);
        chk(d[11:0] == exp_bypass(r, 12), "R5 unassigned 010101", d[11:0], exp_bypass(r, 12));
        shift_ir(6'b110000, cap);
        shift_dr(64'hFFF, 12, d);
        chk(d[11:0] == exp_bypass(64'hFFF, 12), "R5 unassigned 110000", d[11:0], exp_bypass(64'hFFF, 12));

        // five TMS-high edges from Shift-DR
        shift_ir(B_BYPASS, cap);
        step(1, 0); step(0, 0); step(0, 0); step(0, 1); step(0, 1);
        for (int i = 0; i < 5; i++) step(1, 0);
        step(0, 0);
        shift_dr(64'h0, 32, d);
        chk(d[31:0] == ID_EXP, "R1 reset from Shift-DR", d, 64'(ID_EXP));
        // five TMS-high edges from Pause-IR
        shift_ir(B_BYPASS, cap);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0); step(0, 1); step(1, 0); step(0, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        step(0, 0);
        shift_dr(64'h0, 32, d);
        chk(d[31:0] == ID_EXP, "R1 reset from Pause-IR", d, 64'(ID_EXP));

        // debug registers: random traffic through both ports
        for (int k = 0; k < 14; k++) begin
            a = 4'($urandom);
            w = $urandom;
            if ($urandom % 2 == 0) begin
                shift_ir({2'b10, a}, cap);
                shift_dr(64'(w), 32, d);
                chk(d[31:0] == model[a], "R6 debug snapshot", d, 64'(model[a]));
                model[a] = w;
                sys_addr = a; #0.1;
                chk(sys_rdata == w, "R7 JTAG write seen by system port", 64'(sys_rdata), 64'(w));
            end else begin
                sys_write(a, w);
                model[a] = w;
                r = 64'($urandom);
                shift_ir({2'b10, a}, cap);
                shift_dr(r, 32, d);
                chk(d[31:0] == w, "R7 system write seen by JTAG", d, 64'(w));
                model[a] = r[31:0];
            end
        end
        for (int i = 0; i < 16; i++) begin
            sys_addr = 4'(i); #0.1;
            chk(sys_rdata == model[i], "R6 other registers untouched", 64'(sys_rdata), 64'(model[i]));
        end

        // same-edge collision on one register
        clash_addr = 4'd5; clash_data = 32'hDEAD_0005;
        w = 32'h0BAD_F00D;
        shift_ir({2'b10, 4'd5}, cap);
        clash = 1'b1;
        shift_dr(64'(w), 32, d);
        clash = 1'b0;
        sys_addr = 4'd5; #0.1;
        chk(sys_rdata == w, "R7 JTAG wins collision", 64'(sys_rdata), 64'(w));

        // boundary scan: sample and preload
        core_out = 4'($urandom); pin_in = 4'($urandom);
        shift_ir(B_SAMPLE, cap);
        r = 64'($urandom);
        shift_dr(r, 8, d);
        chk(d[7:0] == {core_out, pin_in}, "R8 sample capture", d[7:0], {core_out, pin_in});
        chk(pad_out == core_out, "R8 preload leaves pads", 64'(pad_out), 64'(core_out));

        // EXTEST
        shift_ir(B_EXTEST, cap);
        chk(pad_out == r[7:4], "R9 pads from latches", 64'(pad_out), 64'(r[7:4]));
        core_out = ~core_out; pin_in = 4'($urandom); #0.1;
        chk(pad_out == r[7:4], "R9 core ignored", 64'(pad_out), 64'(r[7:4]));
        w = 32'($urandom);
        shift_dr(64'(w), 8, d);
        chk(d[7:0] == {r[7:4], pin_in}, "R9 extest capture", d[7:0], {r[7:4], pin_in});
        chk(pad_out == w[7:4], "R9 update drives pads", 64'(pad_out), 64'(w[7:4]));

        // asynchronous test reset
        trst_n = 0; #1;
        chk(pad_out == core_out, "R3 trst releases pads", 64'(pad_out), 64'(core_out));
        sys_addr = 4'd5; #0.1;
        chk(sys_rdata == 32'h0, "R7 trst clears registers", 64'(sys_rdata), 0);
        @(negedge tck); #1;
        trst_n = 1;
        step(0, 0);
        shift_dr(64'h0, 32, d);
        chk(d[31:0] == ID_EXP, "R3 IDCODE after trst", d, 64'(ID_EXP));

        chk(en_bad == 0, "R10 tdo_en window", 64'(en_bad), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule